// File: doc/BRIEF.md
# Configurable-Drive GPIO Bank

This block is a single general-purpose I/O bank of up to eight pins. It sits inside a shared configuration register space, and its registers occupy four consecutive addresses that start at a parameterised base. The four registers are pin direction, output level, sampled pin status and drive mode. A host writes these registers with a write strobe and reads them back with a read strobe. The block drives an output value and an output enable for each pad, and it samples the pad inputs.

Each pin can use one of two drive styles. In push-pull mode the pad drives both levels. In open-drain mode the pad only pulls low and otherwise floats. The output level can be loaded before a pin becomes an output, so the pin starts at a chosen level the moment its direction flips. Several banks can share one configuration space by giving each a different base, for example 0xF0, 0xE0, 0xD0 and so on. The pin count can be set anywhere from 4 to 8.

The window decoder is written around an enumerated register selector with four named values: `SEL_DIR` (offset 0), `SEL_DOUT` (offset 1), `SEL_STAT` (offset 2) and `SEL_MODE` (offset 3). It uses a unique case on that selector for both the write path and the read path. The block has no sequencing state machine. Every register access finishes in the cycle of its strobe, and the read result is registered.

Top module: `gpio_bank_drive`

## Requirements
- R1: After reset the direction, output-level and drive-mode registers are all 0, every pad_oe bit is 0 and rd_data is 0x00.
- R2: The registers sit at base+0 (direction), base+1 (output level), base+2 (status) and base+3 (drive mode). A read strobe in one cycle puts the addressed value on rd_data after that clock edge. rd_data then holds until the next read strobe.
- R3: A direction bit of 0 keeps that pad's pad_oe at 0 in every drive mode.
- R4: With direction 1 and drive-mode bit 1 (push-pull), pad_oe is 1 and pad_out equals the output-level bit.
- R5: With direction 1 and drive-mode bit 0 (open-drain), pad_oe is 1 with pad_out 0 when the output-level bit is 0. pad_oe is 0 when that bit is 1.
- R6: The output-level register accepts writes while a pin is an input. The preloaded level appears on the pad in the cycle after the direction write takes effect.
- R7: The status register returns pad_in through a two-stage synchroniser. A read strobe returns the pad value from two clock edges before the strobe edge.
- R8: When the bank has fewer pins than the 8-bit register width, the bits above the pin count read as 0 and writes to them have no effect.
- R9: Reads of any address outside the four-register window return 0x00. Writes to such addresses change no register.
- R10: The status register is read-only. Writes to base+2 leave every register and pad unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Configuration space address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Registered read result |
| pad_in | input | PIN_COUNT | Pad input levels (asynchronous) |
| pad_out | output | PIN_COUNT | Pad output levels |
| pad_oe | output | PIN_COUNT | Pad output enables |

## Verification
The bench targets several cases a faulty design would get wrong.

A level preloaded while a pin is still an input must appear as soon as the direction changes. A design that clears or ignores the output level on a direction change would drive the wrong value.

In open-drain mode a high level must release the pad. A design that drives it would contend with the external pull-up.

The synchroniser depth is checked by reading status right after a pad change. A design with one stage, or with no stages, would return the new value too early.

Writes to the status slot, writes outside the window and writes to bits above a narrow bank's width must all be dropped. A sloppy decoder would let them corrupt the direction, output-level or drive-mode registers. A constrained-random phase then mixes window and near-window traffic against a reference model.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    localparam int WIN_SLOTS = 4;

    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_DOUT = 2'd1,
        SEL_STAT = 2'd2,
        SEL_MODE = 2'd3
    } win_sel_e;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpb_pad_drive.sv
module gpb_pad_drive #(
    parameter int PIN_COUNT = 8
) (
    input  logic [PIN_COUNT-1:0] dir_q,
    input  logic [PIN_COUNT-1:0] dout_q,
    input  logic [PIN_COUNT-1:0] mode_q,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe
);
    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
        always_comb begin
            if (mode_q[i]) begin
                pad_out[i] = dout_q[i];
                pad_oe[i]  = dir_q[i];
            end else begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = dir_q[i] & ~dout_q[i];
            end
        end
    end
endmodule

// File: rtl/gpb_regfile.sv
module gpb_regfile
    import gpb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int REG_W     = 8,
    parameter int PIN_COUNT = 8,
    parameter int WIN_BASE  = 'hF0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [PIN_COUNT-1:0] stat_in,
    output logic [PIN_COUNT-1:0] dir_q,
    output logic [PIN_COUNT-1:0] dout_q,
    output logic [PIN_COUNT-1:0] mode_q,
    output logic [REG_W-1:0]     rd_data
);
    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] SLOTS_A = ADDR_W'(WIN_SLOTS);

    logic [ADDR_W-1:0] offset;
    logic              hit;
    win_sel_e          sel;
    logic [REG_W-1:0]  rd_next;

    assign offset = addr - BASE_A;
    assign hit    = (offset < SLOTS_A);
    assign sel    = win_sel_e'(offset[1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            dout_q <= '0;
            mode_q <= '0;
        end else if (wr_en && hit) begin
            unique case (sel)
                SEL_DIR:  dir_q  <= wdata[PIN_COUNT-1:0];
                SEL_DOUT: dout_q <= wdata[PIN_COUNT-1:0];
                SEL_STAT: ;
                SEL_MODE: mode_q <= wdata[PIN_COUNT-1:0];
            endcase
        end
    end

    always_comb begin
        rd_next = '0;
        if (hit) begin
            unique case (sel)
                SEL_DIR:  rd_next[PIN_COUNT-1:0] = dir_q;
                SEL_DOUT: rd_next[PIN_COUNT-1:0] = dout_q;
                SEL_STAT: rd_next[PIN_COUNT-1:0] = stat_in;
                SEL_MODE: rd_next[PIN_COUNT-1:0] = mode_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    // R9: an out-of-window read must yield zero
    a_r9_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (rd_data == '0));

    // R2: the read result holds without a strobe
    a_r2_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R10: a write to the status slot leaves configuration untouched
    a_r10_status_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && sel == SEL_STAT) |=>
            ($stable(dir_q) && $stable(dout_q) && $stable(mode_q)));

    if (PIN_COUNT < REG_W) begin : g_upper_chk
        // R8: bits above the pin count never read back as 1
        a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[REG_W-1:PIN_COUNT] == '0);
    end
endmodule

// File: rtl/gpio_bank_drive.sv
module gpio_bank_drive #(
    parameter int ADDR_W    = 8,
    parameter int PIN_COUNT = 8,
    parameter int WIN_BASE  = 'hF0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           wdata,
    input  logic                 wr_en,
    input  logic                 rd_en,
    output logic [7:0]           rd_data,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe
);
    localparam int REG_W = 8;

    logic [PIN_COUNT-1:0] stat_q;
    logic [PIN_COUNT-1:0] dir_q;
    logic [PIN_COUNT-1:0] dout_q;
    logic [PIN_COUNT-1:0] mode_q;

    gpb_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (stat_q)
    );

    gpb_regfile #(
        .ADDR_W    (ADDR_W),
        .REG_W     (REG_W),
        .PIN_COUNT (PIN_COUNT),
        .WIN_BASE  (WIN_BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .stat_in (stat_q),
        .dir_q   (dir_q),
        .dout_q  (dout_q),
        .mode_q  (mode_q),
        .rd_data (rd_data)
    );

    gpb_pad_drive #(.PIN_COUNT(PIN_COUNT)) u_drive (
        .dir_q   (dir_q),
        .dout_q  (dout_q),
        .mode_q  (mode_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // R3: an input pin never has its output enabled
    a_r3_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q) == '0);

    // R5: an open-drain pin only ever drives low
    a_r5_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~mode_q & pad_out) == '0);

    // R4: a push-pull output is always enabled
    a_r4_pp_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q & mode_q) & ~pad_oe) == '0);
endmodule

// File: tb/test_gpio_bank_drive.sv
module test_gpio_bank_drive;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data, rd_data_n;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe;
    logic [4:0] pad_in_n = '0;
    logic [4:0] pad_out_n, pad_oe_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_dir = '0, m_dat = '0, m_mod = '0;
    logic [7:0] p1 = '0, p2 = '0;

    always #2.5 clk = ~clk;

    gpio_bank_drive i_gpio_bank_drive (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

    gpio_bank_drive #(.PIN_COUNT(5), .WIN_BASE('hA0)) i_gpio_bank_drive_narrow (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data_n),
        .pad_in(pad_in_n), .pad_out(pad_out_n), .pad_oe(pad_oe_n));

    // reference synchroniser model for the main bank status
    always @(posedge clk) begin
        p2 <= p1;
        p1 <= pad_in;
    end

    function automatic logic [7:0] exp_oe();
        return m_dir & (m_mod | ~m_dat);
    endfunction

    function automatic logic [7:0] exp_out();
        return m_mod & m_dat;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            8'hF0:   return m_dir;
            8'hF1:   return m_dat;
            8'hF2:   return p2;
            8'hF3:   return m_mod;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            8'hF0: m_dir = d;
            8'hF1: m_dat = d;
            8'hF3: m_mod = d;
            default: ;
        endcase
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] got, output logic [7:0] exp);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp = exp_rd(a);
        @(negedge clk);
        rd_en = 1'b0;
        got = rd_data;
    endtask

    task automatic check_pads(input string tag);
        check({tag, " oe"}, pad_oe, exp_oe());
        check({tag, " out"}, pad_out, exp_out());
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] g, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_pads("R1");
        for (int k = 0; k < 4; k++) begin
            do_read(8'hF0 + 8'(k), g, e);
            check("R1 reset read", g, 8'h00);
        end

        // R6 / R3: preload while input, no drive yet
        do_write(8'hF3, 8'hFF);
        do_write(8'hF1, 8'hA5);
        check("R3 input no drive", pad_oe, 8'h00);
        do_write(8'hF0, 8'hFF);
        check("R6 preload out", pad_out, 8'hA5);
        check("R4 pp enable", pad_oe, 8'hFF);

        // R5: open-drain
        do_write(8'hF3, 8'h00);
        check("R5 od enable", pad_oe, 8'h5A);
        check("R5 od level", pad_out, 8'h00);

        // R3: partial direction with mixed mode
        do_write(8'hF3, 8'h0F);
        do_write(8'hF0, 8'h3C);
        check_pads("R3");

        // R10: status write ignored
        do_write(8'hF2, 8'hC3);
        check_pads("R10");
        do_read(8'hF0, g, e); check("R10 dir", g, 8'h3C);
        do_read(8'hF1, g, e); check("R10 dat", g, 8'hA5);
        do_read(8'hF3, g, e); check("R10 mode", g, 8'h0F);

        // R7: two-stage latency
        @(negedge clk);
        pad_in = 8'h96;
        do_read(8'hF2, g, e); check("R7 too early", g, 8'h00);
        do_read(8'hF2, g, e); check("R7 synced", g, 8'h96);

        // R9: out-of-window
        do_read(8'hEF, g, e); check("R9 below", g, 8'h00);
        do_read(8'hF4, g, e); check("R9 above", g, 8'h00);
        do_read(8'hA0, g, e); check("R9 far", g, 8'h00);
        do_write(8'hF4, 8'hFF);
        do_write(8'hEF, 8'hFF);
        do_read(8'hF0, g, e); check("R9 dir kept", g, 8'h3C);
        do_read(8'hF3, g, e); check("R9 mode kept", g, 8'h0F);

        // R8: narrow bank at 0xA0
        do_write(8'hA1, 8'hFF);
        do_write(8'hA3, 8'hFF);
        do_write(8'hA0, 8'hFF);
        check("R8 narrow oe", {3'b0, pad_oe_n}, 8'h1F);
        @(negedge clk); addr = 8'hA1; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check("R8 narrow read", rd_data_n, 8'h1F);
        @(negedge clk); addr = 8'hA0; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check("R8 narrow dir", rd_data_n, 8'h1F);

        // R2 / R4 / R5: constrained random traffic
        void'($urandom(32'h5EED_1234));
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            a = 8'hEC + 8'($urandom_range(0, 11));
            @(negedge clk);
            pad_in = 8'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                do_write(a, 8'($urandom));
                check_pads("R4/R5 random");
            end else begin
                do_read(a, g, e);
                check("R2 random read", g, e);
            end
        end

        // R2: hold without strobe
        do_read(8'hF0, g, e);
        @(negedge clk); addr = 8'hF3;
        @(negedge clk);
        check("R2 hold", rd_data, e);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule